// File: doc/BRIEF.md
# Stencil Grid Traversal Order Sequencer

This block sets the order in which one compute node of a two-dimensional array of nodes updates the grid points of its own rectangular tile, ROWS rows by COLS columns. After a start request it issues exactly one grid-point address per clock, with no gaps, and repeats the pass over the whole tile without end. One pass is one iteration of ROWS×COLS cycles. Alongside each address it reports which tile edges the point lies on. Each marked edge names a neighbouring node that needs the value of that point. A one-cycle flag marks the last point of every iteration.

The order is a row-by-row scan. Each axis is mirrored by the parity of the node's coordinate in the array. Two nodes that share an edge therefore update the two points facing each other across that edge in the same cycle of an iteration. All nodes start on the same clock edge. Each shared value is then produced one full iteration before the neighbour next updates the point that reads it. This gives the link between nodes ROWS×COLS−1 cycles to carry the value, where a plain unmirrored scan allows only about one row.

Top module: `stencil_order_seq`

## Requirements
- R1: While reset is high, and afterwards until a start is accepted, pt_valid, pt_edge, iter_done and pt_dir are all 0.
- R2: A start seen on a rising edge while idle makes the first point of the first iteration visible right after that same edge.
- R3: Once started, pt_valid stays high every cycle. Each iteration of ROWS×COLS consecutive cycles visits every tile point exactly once.
- R4: At step s of an iteration (s = 0 at the first point), the logical row is s / COLS and the logical column is s mod COLS. pt_col is COLS−1−column when the latched x parity is 1, otherwise the column itself. pt_row is ROWS−1−row when the latched y parity is 1, otherwise the row itself.
- R5: x_odd and y_odd are captured only when a start is accepted. Changes to them while running do not alter the order.
- R6: A start request while running is ignored. The sequence continues without restarting.
- R7: iter_done is 1 exactly in the cycle that shows the last point of an iteration (step ROWS×COLS−1), and 0 otherwise.
- R8: pt_dir bit 0 means pt_col = 0 (west neighbour), bit 1 means pt_col = COLS−1 (east), bit 2 means pt_row = 0 (north), bit 3 means pt_row = ROWS−1 (south). pt_edge is 1 when any of these bits is set. Both are 0 when pt_valid is 0.
- R9: For nodes whose parities follow their array coordinates and that start on the same edge, every value on a shared edge is produced at least ROWS×COLS−1 idle cycles before the neighbour next updates the point that reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin issuing points (accepted only when idle) |
| x_odd | input | 1 | Parity of the node's x coordinate; mirrors columns |
| y_odd | input | 1 | Parity of the node's y coordinate; mirrors rows |
| pt_valid | output | 1 | An address is issued this cycle |
| pt_row | output | $clog2(ROWS) | Row of the point updated this cycle |
| pt_col | output | $clog2(COLS) | Column of the point updated this cycle |
| pt_edge | output | 1 | Point lies on a tile edge shared with a neighbour |
| pt_dir | output | 4 | Neighbour directions needing the point: {south, north, east, west} |
| iter_done | output | 1 | Last point of the current iteration |

## Verification
The assertions rely on reset being synchronous and on start being a plain level sampled at the clock. They do not constrain the parity inputs. Those are sampled only at an accepted start, and the bench moves them freely mid-run to show they are ignored. The slack property depends on all nodes starting on the same edge with parities matching their coordinates. The bench therefore drives four instances as a 2×2 array from one start edge. It disturbs only the start and parity pins of a single node after launch, which by requirement must not change its order.

// File: rtl/stencil_seq_pkg.sv
package stencil_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Bit 0 west, bit 1 east, bit 2 north, bit 3 south.
    typedef struct packed {
        logic south;
        logic north;
        logic east;
        logic west;
    } edge_dirs_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stencil_step_counter.sv
module stencil_step_counter
    import stencil_seq_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = idx_bits(ROWS),
    parameter int CW   = idx_bits(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          running,
    output logic          accept,
    output logic [RW-1:0] lrow,
    output logic [CW-1:0] lcol,
    output logic          last
);

    seq_state_e    state_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          col_end;
    logic          row_end;

    assign running = (state_q == SEQ_RUN);
    assign accept  = start & ~running;
    assign col_end = (col_q == CW'(COLS - 1));
    assign row_end = (row_q == RW'(ROWS - 1));
    assign last    = running & col_end & row_end;
    assign lrow    = row_q;
    assign lcol    = col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        row_q   <= '0;
                        col_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (col_end) begin
                        col_q <= '0;
                        row_q <= row_end ? '0 : row_q + RW'(1);
                    end else begin
                        col_q <= col_q + CW'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R2: an accepted start yields the origin step right after the edge
    a_r2_first_step: assert property (@(posedge clk) disable iff (rst)
        accept |=> (running && lrow == '0 && lcol == '0));

    // R3: issuing never stops once begun
    a_r3_keep_running: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    // R7: the step after the last one is the origin of the next pass
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        last |=> (lrow == '0 && lcol == '0));

    // R6: a start mid-pass does not send the scan back to the origin
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (running && start && !last) |=> !(lrow == '0 && lcol == '0));

endmodule

// File: rtl/stencil_axis_map.sv
module stencil_axis_map #(
    parameter int SIZE = 4,
    parameter int W    = 2
) (
    input  logic         flip,
    input  logic [W-1:0] lidx,
    output logic [W-1:0] pidx,
    output logic         at_lo,
    output logic         at_hi
);

    logic [W-1:0] rev;

    assign rev   = W'(SIZE - 1) - lidx;
    assign pidx  = flip ? rev : lidx;
    assign at_lo = (pidx == '0);
    assign at_hi = (pidx == W'(SIZE - 1));

endmodule

// File: rtl/stencil_order_seq.sv
module stencil_order_seq
    import stencil_seq_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW  = idx_bits(ROWS),
    localparam int CW  = idx_bits(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          x_odd,
    input  logic          y_odd,
    output logic          pt_valid,
    output logic [RW-1:0] pt_row,
    output logic [CW-1:0] pt_col,
    output logic          pt_edge,
    output logic [3:0]    pt_dir,
    output logic          iter_done
);

    logic          running;
    logic          accept;
    logic          last;
    logic [RW-1:0] lrow;
    logic [CW-1:0] lcol;
    logic          x_q;
    logic          y_q;
    edge_dirs_t    dirs;

    stencil_step_counter #(
        .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
    ) u_steps (
        .clk(clk), .rst(rst), .start(start),
        .running(running), .accept(accept),
        .lrow(lrow), .lcol(lcol), .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= 1'b0;
            y_q <= 1'b0;
        end else if (accept) begin
            x_q <= x_odd;
            y_q <= y_odd;
        end
    end

    stencil_axis_map #(.SIZE(COLS), .W(CW)) u_cols (
        .flip(x_q), .lidx(lcol), .pidx(pt_col),
        .at_lo(dirs.west), .at_hi(dirs.east)
    );

    stencil_axis_map #(.SIZE(ROWS), .W(RW)) u_rows (
        .flip(y_q), .lidx(lrow), .pidx(pt_row),
        .at_lo(dirs.north), .at_hi(dirs.south)
    );

    assign pt_valid  = running;
    assign pt_dir    = running ? dirs : 4'b0000;
    assign pt_edge   = |pt_dir;
    assign iter_done = last;

    // R5: the latched mirroring stays fixed while points are issued
    a_r5_parity_hold: assert property (@(posedge clk) disable iff (rst)
        pt_valid |=> $stable({x_q, y_q}));

    // R8: a point touches at most two edges (a corner)
    a_r8_dir_count: assert property (@(posedge clk) disable iff (rst)
        $countones(pt_dir) <= 2);

    // R8: edge flag only accompanies an issued point
    a_r8_edge_valid: assert property (@(posedge clk) disable iff (rst)
        pt_edge |-> pt_valid);

    // R7: iteration end only on an issued point
    a_r7_done_valid: assert property (@(posedge clk) disable iff (rst)
        iter_done |-> pt_valid);

    // R4: issued addresses stay inside the tile
    a_r4_in_tile: assert property (@(posedge clk) disable iff (rst)
        pt_valid |-> (int'(pt_row) < ROWS && int'(pt_col) < COLS));

endmodule

// File: tb/tb_stencil_order_seq.sv
module tb_stencil_order_seq;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int NP   = ROWS * COLS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       st [4];
    logic       xo [4];
    logic       yo [4];
    logic       v  [4];
    logic [1:0] r  [4];
    logic [1:0] c  [4];
    logic       e  [4];
    logic [3:0] d  [4];
    logic       dn [4];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int t0  [4][ROWS][COLS];
    int t1  [4][ROWS][COLS];
    int cnt [4][NP];

    stencil_order_seq #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst(rst), .start(st[0]), .x_odd(xo[0]), .y_odd(yo[0]),
        .pt_valid(v[0]), .pt_row(r[0]), .pt_col(c[0]), .pt_edge(e[0]),
        .pt_dir(d[0]), .iter_done(dn[0]));
    stencil_order_seq #(.ROWS(ROWS), .COLS(COLS)) node_e (
        .clk(clk), .rst(rst), .start(st[1]), .x_odd(xo[1]), .y_odd(yo[1]),
        .pt_valid(v[1]), .pt_row(r[1]), .pt_col(c[1]), .pt_edge(e[1]),
        .pt_dir(d[1]), .iter_done(dn[1]));
    stencil_order_seq #(.ROWS(ROWS), .COLS(COLS)) node_s (
        .clk(clk), .rst(rst), .start(st[2]), .x_odd(xo[2]), .y_odd(yo[2]),
        .pt_valid(v[2]), .pt_row(r[2]), .pt_col(c[2]), .pt_edge(e[2]),
        .pt_dir(d[2]), .iter_done(dn[2]));
    stencil_order_seq #(.ROWS(ROWS), .COLS(COLS)) node_se (
        .clk(clk), .rst(rst), .start(st[3]), .x_odd(xo[3]), .y_odd(yo[3]),
        .pt_valid(v[3]), .pt_row(r[3]), .pt_col(c[3]), .pt_edge(e[3]),
        .pt_dir(d[3]), .iter_done(dn[3]));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic check_idle(input int n);
        chk(v[n] == 1'b0 && e[n] == 1'b0 && dn[n] == 1'b0 && d[n] == 4'b0,
            "R1 idle outputs", {v[n], e[n], dn[n], d[n]}, 0);
    endtask

    // Expected point at step k for latched parities xp, yp (R4, R7, R8).
    task automatic check_step(input int n, input int k, input bit xp, input bit yp);
        int s, lr, lc, pr, pc, m;
        s  = k % NP;
        lr = s / COLS;
        lc = s % COLS;
        pr = yp ? (ROWS - 1 - lr) : lr;
        pc = xp ? (COLS - 1 - lc) : lc;
        m  = ((pc == 0) ? 1 : 0) | ((pc == COLS - 1) ? 2 : 0)
           | ((pr == 0) ? 4 : 0) | ((pr == ROWS - 1) ? 8 : 0);
        chk(v[n] == 1'b1, "R3 valid every cycle", v[n], 1);
        chk(int'(r[n]) == pr && int'(c[n]) == pc, "R4 row/col order",
            int'(r[n]) * 16 + int'(c[n]), pr * 16 + pc);
        chk(int'(dn[n]) == ((s == NP - 1) ? 1 : 0), "R7 iteration done",
            dn[n], (s == NP - 1) ? 1 : 0);
        chk(int'(d[n]) == m && int'(e[n]) == ((m != 0) ? 1 : 0), "R8 edge dirs",
            int'(e[n]) * 16 + int'(d[n]), ((m != 0) ? 16 : 0) + m);
    endtask

    initial begin
        int slack_min;
        int sl;
        for (int n = 0; n < 4; n++) begin
            st[n] = 1'b0;
            xo[n] = n[0];
            yo[n] = n[1];
        end

        // Reset and idle (R1)
        repeat (3) @(negedge clk);
        for (int n = 0; n < 4; n++) check_idle(n);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        for (int n = 0; n < 4; n++) check_idle(n);

        // Launch the 2x2 array on one edge
        for (int n = 0; n < 4; n++) st[n] = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 4; n++) st[n] = 1'b0;
        chk(v[0] == 1'b1 && r[0] == 2'd0 && c[0] == 2'd0,
            "R2 first point after start edge", {v[0], r[0], c[0]}, 16);

        for (int k = 0; k < 3 * NP; k++) begin
            if (k % NP == 0)
                for (int n = 0; n < 4; n++)
                    for (int p = 0; p < NP; p++) cnt[n][p] = 0;
            for (int n = 0; n < 4; n++) begin
                check_step(n, k, n[0], n[1]);
                cnt[n][int'(r[n]) * COLS + int'(c[n])]++;
                if (k < NP) t0[n][r[n]][c[n]] = k;
                else if (k < 2 * NP) t1[n][r[n]][c[n]] = k;
            end
            if (k % NP == NP - 1)
                for (int n = 0; n < 4; n++)
                    for (int p = 0; p < NP; p++)
                        chk(cnt[n][p] == 1, "R3 each point once per iteration", cnt[n][p], 1);
            // R5: flip the parity pins of node 0 mid-run
            if (k == 3) begin
                xo[0] = 1'b1;
                yo[0] = 1'b1;
            end
            // R6: a start pulse while running
            if (k == 5) st[0] = 1'b1;
            if (k == 6) st[0] = 1'b0;
            @(negedge clk);
        end

        // R9: slack across every shared edge, both directions
        slack_min = 1 << 30;
        for (int ny = 0; ny < 2; ny++)
            for (int pr = 0; pr < ROWS; pr++) begin
                sl = t1[ny*2+1][pr][0] - t0[ny*2][pr][COLS-1] - 1;
                if (sl < slack_min) slack_min = sl;
                sl = t1[ny*2][pr][COLS-1] - t0[ny*2+1][pr][0] - 1;
                if (sl < slack_min) slack_min = sl;
            end
        for (int nx = 0; nx < 2; nx++)
            for (int pc = 0; pc < COLS; pc++) begin
                sl = t1[2+nx][0][pc] - t0[nx][ROWS-1][pc] - 1;
                if (sl < slack_min) slack_min = sl;
                sl = t1[nx][ROWS-1][pc] - t0[2+nx][0][pc] - 1;
                if (sl < slack_min) slack_min = sl;
            end
        chk(slack_min >= NP - 1, "R9 minimum edge slack", slack_min, NP - 1);

        // Mid-run reset returns to idle (R1)
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int n = 0; n < 4; n++) check_idle(n);
        rst = 1'b0;
        @(negedge clk);
        for (int n = 0; n < 4; n++) check_idle(n);

        // Relaunch node 0 alone: parity pins now 1/1 are captured (R5, R4)
        st[0] = 1'b1;
        @(negedge clk);
        st[0] = 1'b0;
        xo[0] = 1'b0;
        for (int k = 0; k < 2 * NP; k++) begin
            check_step(0, k, 1'b1, 1'b1);
            check_idle(1);
            @(negedge clk);
        end

        finish_run();
    end

endmodule